// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block decides whether a bank of eight interrupt lines should raise a request toward the processor, and which line wins. The caller supplies four things: a pending vector, a mask vector, an in-service vector and a three-bit rotation offset. Priority is counted from the line named by the offset, so the order of precedence can be rotated without changing the priority logic. A request is raised only if the best unmasked pending line has strictly higher precedence than the best line already in service.

When the caller acknowledges the current winner, the block returns the updated in-service vector, with the winner's bit set, and the next rotation offset. The offset becomes the line after the winner when rotate-on-acknowledge is enabled. The block does not hold the in-service vector or the offset itself; the surrounding command logic loads the returned values.

A build parameter adds a secondary resolver. Its request is folded into line 2 of the primary. A primary acknowledge of line 2 also acknowledges the secondary's winner. In special nested mode the primary leaves its own in-service bit 2 out of the current-priority test, so more requests from the secondary can still get through.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the following outputs are 0: `irq_req_o`, `irq_line_o`, `pri_upd_o`, `sec_req_o`, `sec_line_o` and `sec_upd_o`.
- R2: A line is a candidate only when its pending bit is 1 and its mask bit is 0. A masked line never wins, and with no candidate the request output is 0.
- R3: Precedence runs from line `ofs`, then `ofs+1`, and so on, modulo 8. The first candidate in that order wins, and `irq_line_o` gives its absolute line number (0..7). `irq_line_o` is 0 when there is no request.
- R4: A request is raised only when the winner's precedence rank is strictly smaller than the rank of the first in-service line, using the same rotation. An equal rank gives no request. With nothing in service, any candidate raises a request.
- R5: When `sfnm_i` is 1, the primary resolver leaves in-service bit 2 out of the current-priority test. The secondary resolver always uses all of its in-service bits.
- R6: Request and line outputs are registered. For the primary's own lines they reflect the inputs one clock after a change.
- R7: When `ack_i` is pulsed for one cycle while a request is active, the update strobe goes high for exactly one cycle on the next clock. At that point the in-service update equals the input in-service vector with the winner's bit set. The offset update equals the input offset when rotation is off.
- R8: With rotation on, an acknowledge sets the offset update to (winner + 1) mod 8, so a winner on line 7 gives 0.
- R9: An acknowledge while no request is active produces no update strobe.
- R10: With cascade enabled, the secondary's registered request is ORed into primary line 2 before masking, so primary line-2 requests appear two clocks after a secondary input change. A primary acknowledge of line 2 also produces a secondary update strobe, with the secondary's winner set in its in-service update and its own rotation rule. Acknowledges of other primary lines leave the secondary strobe at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| pri_pend_i | input | 8 | Primary pending vector |
| pri_mask_i | input | 8 | Primary mask vector (1 = masked) |
| pri_isr_i | input | 8 | Primary in-service vector |
| pri_ofs_i | input | 3 | Primary rotation offset |
| sfnm_i | input | 1 | Special nested mode enable |
| pri_rot_i | input | 1 | Primary rotate-on-acknowledge enable |
| ack_i | input | 1 | Single-cycle acknowledge strobe |
| sec_pend_i | input | 8 | Secondary pending vector |
| sec_mask_i | input | 8 | Secondary mask vector |
| sec_isr_i | input | 8 | Secondary in-service vector |
| sec_ofs_i | input | 3 | Secondary rotation offset |
| sec_rot_i | input | 1 | Secondary rotate-on-acknowledge enable |
| irq_req_o | output | 1 | Request toward the processor |
| irq_line_o | output | 3 | Primary winning line |
| pri_upd_o | output | 1 | Primary acknowledge update strobe |
| pri_isr_upd_o | output | 8 | Primary in-service vector after acknowledge |
| pri_ofs_upd_o | output | 3 | Primary offset after acknowledge |
| sec_req_o | output | 1 | Secondary request (feeds primary line 2) |
| sec_line_o | output | 3 | Secondary winning line |
| sec_upd_o | output | 1 | Secondary acknowledge update strobe |
| sec_isr_upd_o | output | 8 | Secondary in-service vector after acknowledge |
| sec_ofs_upd_o | output | 3 | Secondary offset after acknowledge |

## Verification
The assertions check four things on every cycle:
- a reported winner was an unmasked pending line in the previous cycle;
- a winner was never already in service;
- update strobes appear only after an accepted acknowledge, and an update carries the winner's in-service bit and the rotated offset;
- a secondary update never appears without a primary one.

The precedence order under different offsets, the strict-versus-equal comparison, special nested mode, the two-clock cascade path and the wrap of the rotated offset from 7 to 0 can only be shown by the bench's scenarios. Each scenario is compared against a model written from the requirements.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDXW  = $clog2(LINES);

  typedef logic [LINES-1:0] vec_t;
  typedef logic [IDXW-1:0]  idx_t;
  // rank 0..LINES-1, value LINES means "no bit set"
  typedef logic [IDXW:0]    prio_t;

  localparam prio_t PRIO_NONE = prio_t'(LINES);
endpackage

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_res_pkg::*;
(
  input  vec_t  vec_i,
  input  idx_t  ofs_i,
  output prio_t prio_o
);
  // Rank of the first set bit when scanning from position ofs_i upward.
  always_comb begin
    idx_t pos;
    pos    = '0;
    prio_o = PRIO_NONE;
    for (int i = LINES - 1; i >= 0; i--) begin
      pos = idx_t'(i) + ofs_i;
      if (vec_i[pos]) begin
        prio_o = prio_t'(i);
      end
    end
  end
endmodule

// File: rtl/irq_res_core.sv
module irq_res_core
  import irq_res_pkg::*;
#(
  parameter idx_t CAS_LINE = idx_t'(2)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  vec_t pend_i,
  input  vec_t mask_i,
  input  vec_t isr_i,
  input  idx_t ofs_i,
  input  logic sfnm_i,
  input  logic is_pri_i,
  input  logic rot_i,
  input  logic ack_i,
  output logic req_o,
  output idx_t line_o,
  output logic upd_o,
  output vec_t isr_upd_o,
  output idx_t ofs_upd_o
);
  vec_t  cand;
  vec_t  cas_bit;
  vec_t  isr_eff;
  prio_t cand_prio;
  prio_t cur_prio;

  logic  req_d, req_q;
  idx_t  line_d, line_q;
  logic  ack_take;
  logic  upd_d, upd_q;
  vec_t  isr_upd_d, isr_upd_q;
  idx_t  ofs_upd_d, ofs_upd_q;

  assign cand    = pend_i & ~mask_i;
  assign cas_bit = vec_t'(1) << CAS_LINE;
  assign isr_eff = (sfnm_i && is_pri_i) ? (isr_i & ~cas_bit) : isr_i;

  irq_prio_scan u_scan_cand (
    .vec_i  (cand),
    .ofs_i  (ofs_i),
    .prio_o (cand_prio)
  );

  irq_prio_scan u_scan_cur (
    .vec_i  (isr_eff),
    .ofs_i  (ofs_i),
    .prio_o (cur_prio)
  );

  // next-state logic
  always_comb begin
    req_d     = (cand_prio < cur_prio);
    line_d    = req_d ? (idx_t'(cand_prio[IDXW-1:0]) + ofs_i) : '0;
    ack_take  = ack_i & req_q;
    upd_d     = ack_take;
    isr_upd_d = isr_i | (vec_t'(1) << line_q);
    ofs_upd_d = rot_i ? (line_q + idx_t'(1)) : ofs_i;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      req_q     <= 1'b0;
      line_q    <= '0;
      upd_q     <= 1'b0;
      isr_upd_q <= '0;
      ofs_upd_q <= '0;
    end else begin
      req_q  <= req_d;
      line_q <= line_d;
      upd_q  <= upd_d;
      if (ack_take) begin
        isr_upd_q <= isr_upd_d;
        ofs_upd_q <= ofs_upd_d;
      end
    end
  end

  assign req_o     = req_q;
  assign line_o    = line_q;
  assign upd_o     = upd_q;
  assign isr_upd_o = isr_upd_q;
  assign ofs_upd_o = ofs_upd_q;

  AST_WIN_WAS_CANDIDATE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    req_q |-> |($past(cand) & (vec_t'(1) << line_q))); // R2

  AST_WIN_NOT_IN_SERVICE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    req_q |-> !(|($past(isr_eff) & (vec_t'(1) << line_q)))); // R4

  AST_NO_ACK_NO_UPD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(ack_i) && !$past(req_q)) |-> !upd_q); // R9

  AST_UPD_SETS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    upd_q |-> isr_upd_q[$past(line_q)]); // R7

  AST_ROTATE_NEXT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (upd_q && $past(rot_i)) |-> (ofs_upd_q == $past(line_q) + idx_t'(1))); // R8
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_res_pkg::*;
#(
  parameter bit          CASCADE  = 1'b1,
  parameter int unsigned CAS_LINE = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [LINES-1:0] pri_pend_i,
  input  logic [LINES-1:0] pri_mask_i,
  input  logic [LINES-1:0] pri_isr_i,
  input  logic [IDXW-1:0]  pri_ofs_i,
  input  logic             sfnm_i,
  input  logic             pri_rot_i,
  input  logic             ack_i,
  input  logic [LINES-1:0] sec_pend_i,
  input  logic [LINES-1:0] sec_mask_i,
  input  logic [LINES-1:0] sec_isr_i,
  input  logic [IDXW-1:0]  sec_ofs_i,
  input  logic             sec_rot_i,
  output logic             irq_req_o,
  output logic [IDXW-1:0]  irq_line_o,
  output logic             pri_upd_o,
  output logic [LINES-1:0] pri_isr_upd_o,
  output logic [IDXW-1:0]  pri_ofs_upd_o,
  output logic             sec_req_o,
  output logic [IDXW-1:0]  sec_line_o,
  output logic             sec_upd_o,
  output logic [LINES-1:0] sec_isr_upd_o,
  output logic [IDXW-1:0]  sec_ofs_upd_o
);
  localparam idx_t CAS_IDX = idx_t'(CAS_LINE);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  vec_t       pri_pend_eff;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  generate
    if (CASCADE) begin : g_cas
      logic sec_ack;
      assign sec_ack      = ack_i & irq_req_o & (irq_line_o == CAS_IDX);
      assign pri_pend_eff = pri_pend_i | (vec_t'(sec_req_o) << CAS_IDX);

      irq_res_core #(.CAS_LINE(CAS_IDX)) u_sec (
        .clk_i     (clk_i),
        .rst_n_i   (rst_core_n),
        .pend_i    (sec_pend_i),
        .mask_i    (sec_mask_i),
        .isr_i     (sec_isr_i),
        .ofs_i     (sec_ofs_i),
        .sfnm_i    (sfnm_i),
        .is_pri_i  (1'b0),
        .rot_i     (sec_rot_i),
        .ack_i     (sec_ack),
        .req_o     (sec_req_o),
        .line_o    (sec_line_o),
        .upd_o     (sec_upd_o),
        .isr_upd_o (sec_isr_upd_o),
        .ofs_upd_o (sec_ofs_upd_o)
      );

      AST_CAS_UPD_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_core_n)
        sec_upd_o |-> pri_upd_o); // R10
    end else begin : g_solo
      assign pri_pend_eff  = pri_pend_i;
      assign sec_req_o     = 1'b0;
      assign sec_line_o    = '0;
      assign sec_upd_o     = 1'b0;
      assign sec_isr_upd_o = '0;
      assign sec_ofs_upd_o = '0;
    end
  endgenerate

  irq_res_core #(.CAS_LINE(CAS_IDX)) u_pri (
    .clk_i     (clk_i),
    .rst_n_i   (rst_core_n),
    .pend_i    (pri_pend_eff),
    .mask_i    (pri_mask_i),
    .isr_i     (pri_isr_i),
    .ofs_i     (pri_ofs_i),
    .sfnm_i    (sfnm_i),
    .is_pri_i  (1'b1),
    .rot_i     (pri_rot_i),
    .ack_i     (ack_i),
    .req_o     (irq_req_o),
    .line_o    (irq_line_o),
    .upd_o     (pri_upd_o),
    .isr_upd_o (pri_isr_upd_o),
    .ofs_upd_o (pri_ofs_upd_o)
  );
endmodule

// File: tb/irq_prio_resolver_tb_top.sv
module irq_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pri_pend = '0, pri_mask = '0, pri_isr = '0;
  logic [2:0] pri_ofs = '0;
  logic       sfnm = 1'b0, pri_rot = 1'b0, ack = 1'b0;
  logic [7:0] sec_pend = '0, sec_mask = '0, sec_isr = '0;
  logic [2:0] sec_ofs = '0;
  logic       sec_rot = 1'b0;
  logic       irq_req, pri_upd, sec_req, sec_upd;
  logic [2:0] irq_line, pri_ofs_upd, sec_line, sec_ofs_upd;
  logic [7:0] pri_isr_upd, sec_isr_upd;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  typedef struct {
    int         due;
    int         sel;
    logic [11:0] exp;
    logic [11:0] msk;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // latest model results, used by the acknowledge task
  logic       m_req, m_sreq;
  logic [2:0] m_line, m_sline;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  irq_prio_resolver dut_i (
    .clk_i(clk), .rst_n_i(rst_n),
    .pri_pend_i(pri_pend), .pri_mask_i(pri_mask), .pri_isr_i(pri_isr),
    .pri_ofs_i(pri_ofs), .sfnm_i(sfnm), .pri_rot_i(pri_rot), .ack_i(ack),
    .sec_pend_i(sec_pend), .sec_mask_i(sec_mask), .sec_isr_i(sec_isr),
    .sec_ofs_i(sec_ofs), .sec_rot_i(sec_rot),
    .irq_req_o(irq_req), .irq_line_o(irq_line), .pri_upd_o(pri_upd),
    .pri_isr_upd_o(pri_isr_upd), .pri_ofs_upd_o(pri_ofs_upd),
    .sec_req_o(sec_req), .sec_line_o(sec_line), .sec_upd_o(sec_upd),
    .sec_isr_upd_o(sec_isr_upd), .sec_ofs_upd_o(sec_ofs_upd)
  );

  // reference: {request, line}; rank counted from ofs upward
  function automatic logic [3:0] mdl(input logic [7:0] cand, input logic [7:0] isr,
                                     input logic [2:0] ofs);
    int pc = 8;
    int pi = 8;
    for (int k = 0; k < 8; k++) begin
      int ln = (int'(ofs) + k) % 8;
      if (cand[ln] && pc == 8) pc = k;
      if (isr[ln] && pi == 8) pi = k;
    end
    if (pc < pi) return {1'b1, 3'((pc + int'(ofs)) % 8)};
    return 4'b0000;
  endfunction

  function automatic logic [11:0] pick(input int sel);
    case (sel)
      0:       return {8'h00, irq_req, irq_line};
      1:       return {pri_upd, pri_isr_upd, pri_ofs_upd};
      2:       return {8'h00, sec_req, sec_line};
      default: return {sec_upd, sec_isr_upd, sec_ofs_upd};
    endcase
  endfunction

  task automatic push(input int due, input int sel, input logic [11:0] exp,
                      input logic [11:0] msk, input string tag);
    item_t it;
    it.due = due; it.sel = sel; it.exp = exp; it.msk = msk; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [11:0] act;
      it  = sb_q.pop_front();
      act = pick(it.sel);
      n_checks++;
      if (((act ^ it.exp) & it.msk) != 12'h000) begin
        n_fails++;
        $display("FAIL %s sel%0d actual=%h expected=%h (mask %h)",
                 it.tag, it.sel, act & it.msk, it.exp & it.msk, it.msk);
      end
    end
  end

  // driver: set inputs, predict, queue expectations
  task automatic apply(input logic [7:0] pp, input logic [7:0] pm, input logic [7:0] pi,
                       input logic [2:0] po, input logic sf,
                       input logic [7:0] sp, input logic [7:0] sm, input logic [7:0] si,
                       input logic [2:0] so, input int lat, input string tag);
    logic [3:0] sr, pr;
    logic [7:0] pisr;
    @(negedge clk);
    pri_pend = pp; pri_mask = pm; pri_isr = pi; pri_ofs = po; sfnm = sf;
    sec_pend = sp; sec_mask = sm; sec_isr = si; sec_ofs = so;
    sr   = mdl(sp & ~sm, si, so);
    pisr = sf ? (pi & ~8'h04) : pi;
    pr   = mdl((pp | (8'(sr[3]) << 2)) & ~pm, pisr, po);
    m_req = pr[3]; m_line = pr[2:0]; m_sreq = sr[3]; m_sline = sr[2:0];
    push(cyc + lat, 0, {8'h00, pr}, 12'h00f, tag);
    push(cyc + lat, 2, {8'h00, sr}, 12'h00f, tag);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_ack(input logic rot, input logic srot, input string tag);
    int base;
    logic [11:0] e;
    @(negedge clk);
    ack = 1'b1; pri_rot = rot; sec_rot = srot;
    base = cyc;
    if (m_req) begin
      e = {1'b1, pri_isr | (8'h01 << m_line), rot ? 3'(m_line + 3'd1) : pri_ofs};
      push(base + 1, 1, e, 12'hfff, tag);
    end else begin
      push(base + 1, 1, 12'h000, 12'h800, "R9");
    end
    if (m_req && m_line == 3'd2 && m_sreq) begin
      e = {1'b1, sec_isr | (8'h01 << m_sline), srot ? 3'(m_sline + 3'd1) : sec_ofs};
      push(base + 1, 3, e, 12'hfff, "R10");
    end else begin
      push(base + 1, 3, 12'h000, 12'h800, "R10");
    end
    @(negedge clk);
    ack = 1'b0;
    push(base + 2, 1, 12'h000, 12'h800, "R7");
    repeat (3) @(negedge clk);
    pri_rot = 1'b0; sec_rot = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    push(cyc + 1, 0, 12'h000, 12'h00f, "R1");
    push(cyc + 1, 1, 12'h000, 12'h800, "R1");
    push(cyc + 1, 2, 12'h000, 12'h00f, "R1");
    push(cyc + 1, 3, 12'h000, 12'h800, "R1");
    repeat (2) @(negedge clk);

    // R3: rotation picks the winner
    apply(8'h28, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R3");
    apply(8'h28, 8'h00, 8'h00, 3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R3");
    apply(8'h21, 8'h00, 8'h00, 3'd6, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R3");
    // R2: masking
    apply(8'h28, 8'h20, 8'h00, 3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R2");
    apply(8'h28, 8'h28, 8'h00, 3'd5, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R2");
    // R4: strict comparison against in-service
    apply(8'h08, 8'h00, 8'h08, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R4");
    apply(8'h08, 8'h00, 8'h10, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R4");
    apply(8'h08, 8'h00, 8'h02, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R4");
    apply(8'h02, 8'h00, 8'h80, 3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R4");
    // R6: one-clock latency for primary lines
    apply(8'h40, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 1, "R6");
    apply(8'h81, 8'h00, 8'h00, 3'd7, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 1, "R6");
    // R5: special nested mode
    apply(8'h00, 8'h00, 8'h04, 3'd0, 1'b0, 8'h01, 8'h00, 8'h00, 3'd0, 2, "R5");
    apply(8'h00, 8'h00, 8'h04, 3'd0, 1'b1, 8'h01, 8'h00, 8'h00, 3'd0, 2, "R5");
    apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b1, 8'h08, 8'h00, 8'h04, 3'd0, 2, "R5");
    // R10: cascade path
    apply(8'h00, 8'h04, 8'h00, 3'd0, 1'b0, 8'h10, 8'h00, 8'h00, 3'd0, 2, "R10");
    apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 8'h10, 8'h00, 8'h00, 3'd0, 2, "R10");
    apply(8'h02, 8'h00, 8'h00, 3'd0, 1'b0, 8'h10, 8'h00, 8'h00, 3'd0, 2, "R10");
    // R7: acknowledge without rotation
    apply(8'h08, 8'h00, 8'h80, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R7");
    do_ack(1'b0, 1'b0, "R7");
    // R8: rotation wraps 7 -> 0
    apply(8'h80, 8'h00, 8'h00, 3'd3, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R8");
    do_ack(1'b1, 1'b0, "R8");
    // R9: acknowledge with no request
    apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 2, "R9");
    do_ack(1'b1, 1'b0, "R9");
    // R10: cascaded acknowledge
    apply(8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 8'h10, 8'h00, 8'h20, 3'd0, 2, "R10");
    do_ack(1'b0, 1'b1, "R10");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule